// File: doc/BRIEF.md
# Time-Slot Data Link Extractor

This block sits on the receive side of a T1/E1 framer. It pulls a low-rate serial data channel out of the framed bit stream. Every clock in which `in_valid` is high, one line bit arrives. Each bit is tagged with the frame counter, the time-slot index and the bit position inside that slot.

A bit is kept only when three tests all pass:
- its frame passes the parity selector;
- its slot equals the programmed slot;
- its bit position is set in the 8-bit mask.

Together these give a channel rate from 4 kbps up to the full 64 kbps of a slot.

Kept bits are packed least-significant-bit first into 8-bit or 6-bit words. Each word goes into a 64-word receive store. The store behaves either as a FIFO over its full depth or as a ring of programmable length that overwrites its oldest word. A processor-side read strobe pops one word at a time. The fill count, an empty flag and a sticky overflow flag are always visible. Framing recovery, HDLC flag handling and FCS checking happen elsewhere. For the HDLC formats this block passes the raw bits through.

Top module: `tsdl_extractor`

## Requirements
- R1: Frame parity comes from `in_frame[0]`, where 1 means odd. The `frame_sel` encoding is: 01 keeps odd frames only, 10 keeps even frames only, and 00 or 11 keeps all frames.
- R2: A bit is captured only when `in_slot` equals `slot_sel` and `bit_mask[in_bitpos]` is 1. Bit positions whose mask bit is 0 are never stored.
- R3: In T1 operation the framing bit arrives tagged slot 0, position 0. Setting `slot_sel` to 0 with mask bit 0 set therefore captures the F bit of each selected frame.
- R4: Captured bits fill a word from bit 0 upward, in arrival order. In Pack8 mode (`mode` = 10) each stored word holds 8 captured bits.
- R5: In Pack6 mode (`mode` = 11) each stored word holds 6 captured bits in bits 5:0, and bits 7:6 read as zero.
- R6: While `enable` is 0, nothing is captured or stored. At the next clock edge the partial word, both pointers, the count and `overflow` are cleared.
- R7: A read strobe pops the oldest word. The word appears on `rd_data` one clock after the strobe edge, and `rd_count` drops by one. `rd_empty` is 1 exactly when the count is 0.
- R8: With `circ_mode` = 0 the store is a 64-word FIFO. A word arriving when it is full is dropped and sets `overflow`, which stays set until reset or until `enable` goes low. Overflow never rises in ring mode.
- R9: With `circ_mode` = 1 the store is a ring of `circ_len` words, where 0 or any value of 64 or more means 64. A word arriving when the ring is full overwrites the oldest word, and the count stays at the length.
- R10: Mode codes 00 and 01 (HDLC formats) pass the raw captured bits through, packed 8 per word exactly as in Pack8.
- R11: A read strobe while the store is empty returns 0 on `rd_data` and changes neither the pointers nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low clears all state |
| mode | input | 2 | Word format: 00/01 raw HDLC, 10 Pack8, 11 Pack6 |
| frame_sel | input | 2 | Frame parity selector |
| slot_sel | input | SLOT_W | Selected time slot |
| bit_mask | input | 8 | Bit positions captured within the slot |
| circ_mode | input | 1 | 1 = ring buffer, 0 = full-depth FIFO |
| circ_len | input | CNT_W | Ring length in words |
| in_valid | input | 1 | Line bit present this cycle |
| in_bit | input | 1 | Line bit |
| in_frame | input | FRAME_W | Frame counter of the bit |
| in_slot | input | SLOT_W | Time-slot index of the bit |
| in_bitpos | input | 3 | Bit position within the slot |
| rd_strobe | input | 1 | Pop one word |
| rd_data | output | 8 | Word read by the last strobe |
| rd_count | output | CNT_W | Words held |
| rd_empty | output | 1 | Store is empty |
| overflow | output | 1 | Sticky FIFO overflow |

## Verification
The checker watches, on every cycle, the properties that hold at the ports regardless of the data:
- the count never exceeds the depth;
- a disabled controller is empty and has no overflow on the next cycle;
- once set, overflow stays set while the controller is enabled;
- overflow never rises in ring mode;
- a read of an empty store returns zero.

The bench's scenarios are needed for the rest, because only a reference model fed the same stream can confirm them:
- which bits are selected by parity, slot and mask;
- the bit order and the upper bits of Pack6 words;
- that a partial word is discarded;
- that the ring keeps the newest words while the FIFO keeps the oldest.

// File: rtl/tsdl_pkg.sv
package tsdl_pkg;
    localparam int SLOT_BITS   = 8;
    localparam int NARROW_BITS = 6;

    typedef enum logic [1:0] {
        FSEL_ALL  = 2'b00,
        FSEL_ODD  = 2'b01,
        FSEL_EVEN = 2'b10,
        FSEL_ANY  = 2'b11
    } fsel_e;

    localparam logic [1:0] MODE_PACK6 = 2'b11;
endpackage

// File: rtl/tsdl_bit_select.sv
module tsdl_bit_select
    import tsdl_pkg::*;
#(
    parameter int SLOT_W  = 5,
    parameter int FRAME_W = 8
) (
    input  logic               enable,
    input  logic               in_valid,
    input  logic [FRAME_W-1:0] in_frame,
    input  logic [SLOT_W-1:0]  in_slot,
    input  logic [2:0]         in_bitpos,
    input  logic [1:0]         frame_sel,
    input  logic [SLOT_W-1:0]  slot_sel,
    input  logic [7:0]         bit_mask,
    output logic               take
);
    logic frame_ok;

    always_comb begin
        case (fsel_e'(frame_sel))
            FSEL_ODD:  frame_ok = in_frame[0];
            FSEL_EVEN: frame_ok = ~in_frame[0];
            default:   frame_ok = 1'b1;
        endcase
        take = enable & in_valid & frame_ok
             & (in_slot == slot_sel) & bit_mask[in_bitpos];
    end
endmodule

// File: rtl/tsdl_packer.sv
module tsdl_packer
    import tsdl_pkg::*;
#(
    parameter int WORD_W = SLOT_BITS,
    localparam int CNT_W = $clog2(WORD_W) + 1,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pack6,
    input  logic              take,
    input  logic              bit_in,
    output logic              wr_valid,
    output logic [WORD_W-1:0] wr_data
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [WORD_W-1:0] word;
    } pk_t;

    pk_t pk_d, pk_q;
    logic [WORD_W-1:0] acc_next;
    logic [CNT_W-1:0]  limit;

    always_comb begin
        pk_d     = pk_q;
        pk_d.vld = 1'b0;
        acc_next = pk_q.acc;
        limit    = pack6 ? CNT_W'(NARROW_BITS) : CNT_W'(WORD_W);
        if (!enable) begin
            pk_d.acc = '0;
            pk_d.cnt = '0;
        end else if (take) begin
            acc_next[pk_q.cnt[IDX_W-1:0]] = bit_in;
            if (pk_q.cnt + CNT_W'(1) >= limit) begin
                pk_d.word = acc_next;
                pk_d.vld  = 1'b1;
                pk_d.acc  = '0;
                pk_d.cnt  = '0;
            end else begin
                pk_d.acc = acc_next;
                pk_d.cnt = pk_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign wr_valid = pk_q.vld;
    assign wr_data  = pk_q.word;
endmodule

// File: rtl/tsdl_rx_buffer.sv
module tsdl_rx_buffer #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              circ_mode,
    input  logic [CNT_W-1:0]  circ_len,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_count,
    output logic              rd_empty,
    output logic              overflow
);
    typedef struct packed {
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [CNT_W-1:0]  count;
        logic              ovf;
        logic [WORD_W-1:0] rdata;
    } buf_t;

    buf_t b_d, b_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic              do_write;
    logic [CNT_W-1:0]  lim;
    logic [CNT_W-1:0]  cnt_after;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p,
                                                 input logic [CNT_W-1:0] l);
        if ({1'b0, p} + CNT_W'(1) >= l) return '0;
        return p + PTR_W'(1);
    endfunction

    always_comb begin
        b_d       = b_q;
        do_write  = 1'b0;
        cnt_after = b_q.count;
        lim       = (circ_mode && circ_len != '0 && circ_len < CNT_W'(DEPTH))
                    ? circ_len : CNT_W'(DEPTH);
        if (!enable) begin
            b_d = '0;
        end else begin
            if (rd_strobe) begin
                if (b_q.count != '0) begin
                    b_d.rdata = mem[b_q.rptr];
                    b_d.rptr  = ptr_inc(b_q.rptr, lim);
                    cnt_after = b_q.count - CNT_W'(1);
                end else begin
                    b_d.rdata = '0;
                end
            end
            if (wr_valid) begin
                if (cnt_after < lim) begin
                    do_write  = 1'b1;
                    b_d.wptr  = ptr_inc(b_q.wptr, lim);
                    cnt_after = cnt_after + CNT_W'(1);
                end else if (circ_mode) begin
                    do_write = 1'b1;
                    b_d.wptr = ptr_inc(b_q.wptr, lim);
                    b_d.rptr = ptr_inc(b_d.rptr, lim);
                end else begin
                    b_d.ovf = 1'b1;
                end
            end
            b_d.count = cnt_after;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[b_q.wptr] <= wr_data;
    end

    assign rd_data  = b_q.rdata;
    assign rd_count = b_q.count;
    assign rd_empty = (b_q.count == '0);
    assign overflow = b_q.ovf;
endmodule

// File: rtl/tsdl_extractor.sv
module tsdl_extractor
    import tsdl_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int SLOT_W  = 5,
    parameter int FRAME_W = 8,
    localparam int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [1:0]           mode,
    input  logic [1:0]           frame_sel,
    input  logic [SLOT_W-1:0]    slot_sel,
    input  logic [7:0]           bit_mask,
    input  logic                 circ_mode,
    input  logic [CNT_W-1:0]     circ_len,
    input  logic                 in_valid,
    input  logic                 in_bit,
    input  logic [FRAME_W-1:0]   in_frame,
    input  logic [SLOT_W-1:0]    in_slot,
    input  logic [2:0]           in_bitpos,
    input  logic                 rd_strobe,
    output logic [SLOT_BITS-1:0] rd_data,
    output logic [CNT_W-1:0]     rd_count,
    output logic                 rd_empty,
    output logic                 overflow
);
    logic                 take;
    logic                 wr_valid;
    logic [SLOT_BITS-1:0] wr_data;

    tsdl_bit_select #(.SLOT_W(SLOT_W), .FRAME_W(FRAME_W)) sel_i (
        .enable(enable), .in_valid(in_valid), .in_frame(in_frame),
        .in_slot(in_slot), .in_bitpos(in_bitpos), .frame_sel(frame_sel),
        .slot_sel(slot_sel), .bit_mask(bit_mask), .take(take)
    );

    tsdl_packer #(.WORD_W(SLOT_BITS)) pack_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .pack6(mode == MODE_PACK6), .take(take), .bit_in(in_bit),
        .wr_valid(wr_valid), .wr_data(wr_data)
    );

    tsdl_rx_buffer #(.DEPTH(DEPTH), .WORD_W(SLOT_BITS)) buf_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .circ_mode(circ_mode),
        .circ_len(circ_len), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_count(rd_count),
        .rd_empty(rd_empty), .overflow(overflow)
    );
endmodule

// File: rtl/tsdl_extractor_checker.sv
module tsdl_extractor_checker #(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             circ_mode,
    input logic             rd_strobe,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] rd_count,
    input logic             rd_empty,
    input logic             overflow
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_count <= CNT_W'(DEPTH)); // R9
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (rd_count == '0 && !overflow)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && overflow) |=> overflow); // R8
    AST_OVF_FIFO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !$past(circ_mode)); // R8
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rd_strobe && rd_empty) |=> (rd_data == 8'h00)); // R11
endmodule

bind tsdl_extractor tsdl_extractor_checker #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .circ_mode(circ_mode),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_count(rd_count),
    .rd_empty(rd_empty), .overflow(overflow)
);

// File: tb/tsdl_extractor_tb_top.sv
module tsdl_extractor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] mode = 2'b10;
    logic [1:0] frame_sel = 2'b00;
    logic [4:0] slot_sel = '0;
    logic [7:0] bit_mask = '0;
    logic       circ_mode = 1'b0;
    logic [6:0] circ_len = '0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic [7:0] in_frame = '0;
    logic [4:0] in_slot = '0;
    logic [2:0] in_bitpos = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] rd_count;
    logic       rd_empty;
    logic       overflow;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mq[$];
    logic [7:0] m_acc;
    int         m_cnt;
    bit         m_ovf;

    always #4 clk = ~clk;

    tsdl_extractor dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .frame_sel(frame_sel), .slot_sel(slot_sel), .bit_mask(bit_mask),
        .circ_mode(circ_mode), .circ_len(circ_len), .in_valid(in_valid),
        .in_bit(in_bit), .in_frame(in_frame), .in_slot(in_slot),
        .in_bitpos(in_bitpos), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rd_count(rd_count), .rd_empty(rd_empty), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ring_len();
        if (circ_mode && circ_len != 0 && circ_len < 64) return int'(circ_len);
        return 64;
    endfunction

    function automatic void m_push(input logic [7:0] w);
        if (mq.size() < ring_len()) mq.push_back(w);
        else if (circ_mode) begin
            void'(mq.pop_front());
            mq.push_back(w);
        end else m_ovf = 1;
    endfunction

    function automatic bit m_match(input int f, input int s, input int p);
        bit fok;
        case (frame_sel)
            2'b01:   fok = (f % 2) == 1;
            2'b10:   fok = (f % 2) == 0;
            default: fok = 1;
        endcase
        return enable && fok && (s == int'(slot_sel)) && bit_mask[p];
    endfunction

    function automatic void m_take(input logic b);
        int lim;
        lim = (mode == 2'b11) ? 6 : 8;
        m_acc[m_cnt] = b;
        m_cnt++;
        if (m_cnt >= lim) begin
            m_push(m_acc);
            m_acc = '0;
            m_cnt = 0;
        end
    endfunction

    function automatic void m_clear();
        mq.delete();
        m_ovf = 0;
        m_acc = '0;
        m_cnt = 0;
    endfunction

    task automatic feed_one(input int f, input int s, input int p);
        logic b;
        @(negedge clk);
        b = logic'($urandom() & 1);
        in_valid = 1'b1; in_bit = b;
        in_frame = 8'(f); in_slot = 5'(s); in_bitpos = 3'(p);
        if (m_match(f, s, p)) m_take(b);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic feed_frame(input int f);
        feed_one(f, 0, 0);                // R3 F bit tag
        for (int s = 1; s <= 24; s++)
            for (int p = 0; p < 8; p++) feed_one(f, s, p);
    endtask

    task automatic feed_frames(input int first, input int n);
        for (int f = first; f < first + n; f++) feed_frame(f);
        idle(3);
    endtask

    task automatic restart(input logic [1:0] md, input logic [1:0] fs,
                           input int sl, input logic [7:0] mk,
                           input bit cm, input int cl);
        @(negedge clk);
        enable = 1'b0;
        m_clear();
        mode = md; frame_sel = fs; slot_sel = 5'(sl); bit_mask = mk;
        circ_mode = cm; circ_len = 7'(cl);
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic drain(input string req);
        chk({req, " count"}, int'(rd_count), mq.size());
        chk({req, " empty"}, int'(rd_empty), int'(mq.size() == 0));
        while (mq.size() != 0) begin
            logic [7:0] e;
            e = mq.pop_front();
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            chk({req, " data"}, int'(rd_data), int'(e));
        end
        chk({req, " drained"}, int'(rd_count), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset count", int'(rd_count), 0);
        chk("R7 reset empty", int'(rd_empty), 1);
        chk("R8 reset overflow", int'(overflow), 0);
        chk("R11 reset data", int'(rd_data), 0);

        // R6: disabled controller stores nothing
        slot_sel = 5'd3; bit_mask = 8'hFF;
        feed_frames(0, 2);
        chk("R6 disabled count", int'(rd_count), 0);

        // R1 R3 R4: F bit in odd frames, Pack8
        restart(2'b10, 2'b01, 0, 8'h01, 0, 0);
        feed_frames(1, 40);
        drain("R3 odd F bits Pack8");

        // R1 R5: even frames, whole slot, Pack6
        restart(2'b11, 2'b10, 5, 8'hFF, 0, 0);
        feed_frames(0, 6);
        for (int i = 0; i < mq.size(); i++)
            chk("R5 upper bits zero", int'(mq[i][7:6]), 0);
        drain("R5 even Pack6");

        // R2: sparse mask, all frames
        restart(2'b10, 2'b00, 24, 8'h81, 0, 0);
        feed_frames(0, 12);
        drain("R2 mask 81");

        // R8: FIFO overflow
        restart(2'b10, 2'b11, 3, 8'hFF, 0, 0);
        feed_frames(0, 70);
        chk("R8 overflow set", int'(overflow), int'(m_ovf));
        chk("R8 full count", int'(rd_count), 64);
        drain("R8 FIFO keeps oldest");
        chk("R8 overflow sticky", int'(overflow), 1);
        @(negedge clk); enable = 1'b0; @(negedge clk);
        chk("R6 overflow cleared", int'(overflow), 0);

        // R9: ring of length 10
        restart(2'b10, 2'b00, 2, 8'hFF, 1, 10);
        feed_frames(0, 25);
        chk("R9 ring overflow", int'(overflow), 0);
        drain("R9 ring keeps newest");

        // R6: partial word discarded on disable
        restart(2'b10, 2'b00, 7, 8'hFF, 0, 0);
        feed_one(0, 7, 0); feed_one(0, 7, 1); feed_one(0, 7, 2);
        idle(1);
        @(negedge clk); enable = 1'b0; m_clear();
        @(negedge clk); enable = 1'b1;
        feed_frames(1, 1);
        drain("R6 partial discarded");

        // R11: empty read
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        chk("R11 empty read data", int'(rd_data), 0);
        chk("R11 empty read count", int'(rd_count), 0);
        feed_frames(2, 2);
        drain("R11 pointers intact");

        // R10: raw HDLC modes behave as Pack8
        restart(2'b00, 2'b00, 9, 8'h3C, 0, 0);
        feed_frames(0, 6);
        drain("R10 mode 00");
        restart(2'b01, 2'b01, 1, 8'hF0, 0, 0);
        feed_frames(0, 8);
        drain("R10 mode 01");

        // random configurations
        for (int k = 0; k < 6; k++) begin
            restart(2'($urandom()), 2'($urandom()), int'($urandom() % 25),
                    8'($urandom() | 1), bit'($urandom() & 1),
                    int'($urandom() % 64));
            feed_frames(int'($urandom() % 4), 12);
            chk("R8 random overflow", int'(overflow), int'(m_ovf));
            drain("R1 R2 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule